// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a simple on-chip request port and an external asynchronous static RAM of 256K words by 16 bits. It turns each accepted read or write request into a timed sequence of active-low strobes on the memory side: chip select, output enable, write enable, and one enable for each 8-bit lane. The strobe timing is counted in system-clock cycles. The cycle count is derived from a parameterised access time (55 ns or 70 ns) and the clock period.

The memory data bus is bidirectional. It is modelled here as a separate outgoing value, an incoming value and a drive enable. The controller drives the bus only during writes, and only while output enable is inactive. On a read it never drives the bus. It captures the incoming word on the final wait cycle and holds that word on its read-data output.

A request whose byte mask is all zero finishes at once and produces no strobe at the memory. After every access, one idle cycle lets the bus turn around before the next request is taken.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, chip select, output enable, write enable and both lane enables are high (inactive), the bus drive enable is low, and ready is high.
- R2: A read holds chip select and output enable low, with write enable high, for exactly W cycles, where W = ceil(ACCESS_NS / CLK_NS) (6 at the defaults). The bus drive enable stays low throughout the read.
- R3: The read-data output takes the incoming bus value at the end of the last of the W read cycles. It keeps that value until the next read captures a new one. Lanes whose mask bit is 0 carry unspecified data.
- R4: A write consists of 1 setup cycle (chip select low, write enable high), then W cycles with write enable low, then 1 hold cycle with all strobes high.
- R5: The bus drive enable is high from the write setup cycle through the hold cycle, and at no other time. Output enable is high in every cycle where the bus is driven.
- R6: The address and the outgoing data stay unchanged from the setup cycle through the hold cycle. The address stays unchanged for the whole of a read.
- R7: Mask bit 0 controls lane enable bit 0, which gates data bits 7:0. Mask bit 1 controls lane enable bit 1, which gates data bits 15:8. A lane enable is low exactly when chip select is low and its mask bit is 1.
- R8: A request with mask 2'b00 produces no strobe at all. Ready goes low for exactly one cycle.
- R9: A request is accepted on a clock edge where valid and ready are both high. Ready stays low from that edge until the access ends, plus one turnaround cycle. Valid while ready is low is ignored.
- R10: Write enable is never low unless chip select is low and output enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_ready | output | 1 | Controller idle and able to accept |
| rsp_rdata | output | 16 | Most recently captured read word |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | 2 | Lane enables, active low, bit 0 = low byte |
| mem_dq_out | output | 16 | Data driven onto the memory bus |
| mem_dq_in | input | 16 | Data returned from the memory bus |
| mem_dq_oe | output | 1 | Bus drive enable |

## Verification
The hardest situation to reach from the ports is a request that is offered while the controller is busy, or on the cycle when the controller is still in its turnaround gap. A careless handshake would accept that request early. The stimulus raises valid with a conflicting write in the middle of a read and drops it before ready returns. It then issues requests back to back, so that each new one waits through the gap.

A behavioural memory in the bench stores lanes only when the strobes say so. Reads with partial masks therefore expose any wrong lane gating or misplaced write data. The reads also cover the top address of the array.

// File: rtl/sram_lane_pkg.sv
// Shared types and helpers for the SRAM lane controller.
// Assumes the access time and the clock period are positive integers in ns.
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_GAP
    } ctl_state_t;

    // Whole number of clock cycles that covers an access time, at least one.
    function automatic int wait_cycles(input int access_ns, input int clk_ns);
        int c;
        c = (access_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
// Down-counter that measures one strobe window of CYCLES clock cycles.
// A load pulse starts the window. done is high in the last cycle of the window
// and stays high while the counter is idle. Assumes CYCLES >= 1.
module sram_wait_timer #(
    parameter int CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    // Count down from the load value to zero, then rest.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= LOAD_VAL;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/sram_lane_map.sv
// Maps a lane mask onto the active-low lane enables, one enable per lane.
// When the access is not active, every enable is high.
module sram_lane_map #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0] mask,
    input  logic             active,
    output logic [LANES-1:0] en_n
);
    // One independent gate per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign en_n[g] = !(active && mask[g]);
    end

endmodule

// File: rtl/sram_lane_ctrl.sv
// Controller for an asynchronous SRAM with per-lane enables.
// It accepts one request at a time through a valid/ready handshake. It runs a
// read or write strobe sequence whose length is set by ACCESS_NS and CLK_NS.
// A single turnaround cycle is inserted before it accepts again.
// Every memory-side output is registered, so the strobes are glitch free.
// Assumes DATA_W is a multiple of LANES.
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 16,
    parameter int LANES     = 2,
    parameter int CLK_NS    = 10,
    parameter int ACCESS_NS = 55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [LANES-1:0]  mem_be_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int WAIT_CYC = wait_cycles(ACCESS_NS, CLK_NS);

    ctl_state_t       state, nxt;
    logic [LANES-1:0] mask_q, mask_sel, be_nxt;
    logic             accept, t_load, t_done, sel_active;

    assign accept = req_valid && req_ready;

    // Next-state decision for the strobe sequence.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:   if (accept) nxt = (req_mask == '0) ? ST_GAP :
                                         (req_write ? ST_WSETUP : ST_READ);
            ST_READ:   if (t_done) nxt = ST_GAP;
            ST_WSETUP: nxt = ST_WPULSE;
            ST_WPULSE: if (t_done) nxt = ST_WHOLD;
            ST_WHOLD:  nxt = ST_GAP;
            ST_GAP:    nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Start the wait window when a read is accepted or a write leaves setup.
    assign t_load = (state == ST_IDLE && accept && !req_write && req_mask != '0)
                 || (state == ST_WSETUP);

    sram_wait_timer #(.CYCLES(WAIT_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (t_load),
        .done  (t_done)
    );

    assign mask_sel   = (state == ST_IDLE) ? req_mask : mask_q;
    assign sel_active = (nxt == ST_READ) || (nxt == ST_WSETUP) || (nxt == ST_WPULSE);

    sram_lane_map #(.LANES(LANES)) u_lanes (
        .mask   (mask_sel),
        .active (sel_active),
        .en_n   (be_nxt)
    );

    // State register and registered strobes derived from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            req_ready <= 1'b1;
            mem_ce_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_be_n  <= '1;
            mem_dq_oe <= 1'b0;
        end else begin
            state     <= nxt;
            req_ready <= (nxt == ST_IDLE);
            mem_ce_n  <= !sel_active;
            mem_oe_n  <= !(nxt == ST_READ);
            mem_we_n  <= !(nxt == ST_WPULSE);
            mem_be_n  <= be_nxt;
            mem_dq_oe <= (nxt == ST_WSETUP) || (nxt == ST_WPULSE) || (nxt == ST_WHOLD);
        end
    end

    // Latch the request fields at acceptance so they stay stable for the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
            mask_q     <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
            mask_q     <= req_mask;
        end
    end

    // Capture the returning word at the end of the last read wait cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rsp_rdata <= '0;
        else if (state == ST_READ && t_done) rsp_rdata <= mem_dq_in;
    end

    // The bus is never driven while the memory may be driving it (R5).
    p_no_drive_in_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // Write enable only with chip select low and output enable high (R10).
    p_we_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));

    // Address and data hold through the write pulse and into the hold cycle (R6).
    p_we_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> ($stable(mem_dq_out) && $stable(mem_addr) && mem_dq_oe));

    // Lane enables fall only while chip select is low (R7).
    p_lane_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (&mem_be_n));

    // An accepted request drops ready on the next cycle (R9).
    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // An empty mask produces no strobe (R8).
    p_empty_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mask == '0) |=> (mem_ce_n && mem_we_n && mem_oe_n));

endmodule

// File: tb/tb_sram_lane_ctrl.sv
module tb_sram_lane_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ACC_NS     = 55;
    localparam int W          = (ACC_NS + CLK_PERIOD - 1) / CLK_PERIOD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [15:0] rsp_rdata, mem_dq_out, mem_dq_in;
    logic [17:0] mem_addr;
    logic [1:0]  mem_be_n;

    int checks = 0, failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_lane_ctrl #(.CLK_NS(CLK_PERIOD), .ACCESS_NS(ACC_NS)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe)
    );

    // Behavioural asynchronous memory, 1024 words, indexed by the low address bits.
    logic [15:0] sram [0:1023];
    logic [15:0] refm [0:1023];
    initial for (int i = 0; i < 1024; i++) begin sram[i] = '0; refm[i] = '0; end

    always_comb begin
        mem_dq_in = 16'h0000;
        if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
            if (!mem_be_n[0]) mem_dq_in[7:0]  = sram[mem_addr[9:0]][7:0];
            if (!mem_be_n[1]) mem_dq_in[15:8] = sram[mem_addr[9:0]][15:8];
        end
    end

    always @(posedge clk)
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
            if (!mem_be_n[0]) sram[mem_addr[9:0]][7:0]  <= mem_dq_out[7:0];
            if (!mem_be_n[1]) sram[mem_addr[9:0]][15:8] <= mem_dq_out[15:8];
        end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s t=%0t act=%h exp=%h", tag, $time, act, exp);
        end
    endtask

    // Reference model: kind 0 idle, 1 read, 2 write, 3 empty mask; step counts cycles since accept.
    int          kind = 0, step = 0;
    logic [17:0] m_addr;
    logic [15:0] m_wd;
    logic [1:0]  m_mask;
    bit          rd_done = 0;

    function automatic int seq_len(input int k);
        return (k == 1) ? W + 1 : (k == 2) ? W + 3 : 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            kind = 0; step = 0;
        end else if (kind == 0) begin
            if (req_valid) begin
                m_addr = req_addr; m_wd = req_wdata; m_mask = req_mask;
                kind = (req_mask == 2'b00) ? 3 : (req_write ? 2 : 1);
                step = 1;
                if (kind == 2) begin
                    if (req_mask[0]) refm[req_addr[9:0]][7:0]  = req_wdata[7:0];
                    if (req_mask[1]) refm[req_addr[9:0]][15:8] = req_wdata[15:8];
                end
            end
        end else if (step == seq_len(kind)) begin
            if (kind == 1) rd_done = 1;
            kind = 0; step = 0;
        end else begin
            step++;
        end
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        logic e_ce, e_oe, e_we, e_oen;
        logic [1:0] e_be;
        logic [15:0] e_rd, msk;
        if (rst_n && !finished) begin
            e_ce = 1; e_oe = 1; e_we = 1; e_oen = 0;
            if (kind == 1 && step <= W) begin e_ce = 0; e_oe = 0; end
            if (kind == 2) begin
                if (step <= W + 1) e_ce = 0;
                if (step >= 2 && step <= W + 1) e_we = 0;
                if (step <= W + 2) e_oen = 1;
            end
            e_be = e_ce ? 2'b11 : ~m_mask;
            check("R9 ready", 32'(req_ready), 32'(kind == 0));
            check("R2/R4 ce_n", 32'(mem_ce_n), 32'(e_ce));
            check("R2 oe_n", 32'(mem_oe_n), 32'(e_oe));
            check("R4 we_n", 32'(mem_we_n), 32'(e_we));
            check("R5 dq_oe", 32'(mem_dq_oe), 32'(e_oen));
            check("R7 be_n", 32'(mem_be_n), 32'(e_be));
            check("R10 we_oe", 32'(!mem_we_n && !mem_oe_n), 32'(0));
            if (!e_ce || e_oen) check("R6 addr", 32'(mem_addr), 32'(m_addr));
            if (e_oen) check("R6 wdata", 32'(mem_dq_out), 32'(m_wd));
            if (rd_done) begin
                msk  = {{8{m_mask[1]}}, {8{m_mask[0]}}};
                e_rd = refm[m_addr[9:0]] & msk;
                check("R3 rdata", 32'(rsp_rdata & msk), 32'(e_rd));
                rd_done = 0;
            end
        end
    end

    task automatic issue(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state seen while reset is held
        check("R1 ce_n", 32'(mem_ce_n), 32'(1));
        check("R1 oe_n/we_n", 32'({mem_oe_n, mem_we_n}), 32'(2'b11));
        check("R1 be_n", 32'(mem_be_n), 32'(2'b11));
        check("R1 dq_oe", 32'(mem_dq_oe), 32'(0));
        check("R1 ready", 32'(req_ready), 32'(1));
        rst_n = 1;
        issue(1, 18'h00010, 16'hA55A, 2'b11);
        issue(0, 18'h00010, 16'h0000, 2'b11);
        issue(1, 18'h00010, 16'h1234, 2'b01);   // low lane only
        issue(0, 18'h00010, 16'h0000, 2'b11);
        issue(1, 18'h00010, 16'hBEEF, 2'b10);   // high lane only
        issue(0, 18'h00010, 16'h0000, 2'b11);
        issue(0, 18'h00010, 16'h0000, 2'b01);
        issue(1, 18'h00020, 16'hFFFF, 2'b00);   // R8: empty mask, no strobes
        issue(0, 18'h00020, 16'h0000, 2'b11);
        issue(1, 18'h3FFFF, 16'hC3C3, 2'b11);   // top address
        issue(0, 18'h3FFFF, 16'h0000, 2'b10);
        // R9: valid offered mid-read is ignored until ready returns
        issue(0, 18'h00010, 16'h0000, 2'b11);
        req_valid = 1; req_write = 1; req_addr = 18'h00010; req_wdata = 16'h0BAD; req_mask = 2'b11;
        repeat (3) @(negedge clk);
        req_valid = 0;
        issue(0, 18'h00010, 16'h0000, 2'b11);
        issue(0, 18'h00020, 16'h0000, 2'b00);
        for (int i = 0; i < 4; i++) issue(1, 18'(i * 3), 16'(16'h1111 * (i + 1)), 2'(i));
        for (int i = 0; i < 4; i++) issue(0, 18'(i * 3), 16'h0000, 2'b11);
        repeat (W + 6) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule